// File: doc/BRIEF.md
# Shared-Memory Bank Conflict Cycle Calculator

This block works out how many arbitration cycles a banked shared memory needs to serve one issue group. The group is a primary warp instruction plus up to three co-issued lane sets taken from other sources. Each lane brings a byte address. The bank is taken from the address bits just above the word offset. The word identifier is the address with the offset bits dropped. All participating lanes from all sets are pooled, as one arbiter would see them. For each bank the block counts the distinct words requested. The largest such count is the number of cycles the group occupies the memory.

For comparison it also reports the larger of the cycle counts that the primary and each shared set carry on their own. These counts are computed upstream one set at a time.

A one-cycle `inValid` strobe captures the whole group. The block then examines one lane slot per clock, in slot order: the primary's lanes 0..31 first, then set 0, set 1 and set 2. A lane adds to its bank's count only if no earlier live slot holds the same word. The result is published with a one-cycle `outValid` pulse at a fixed latency. The outputs keep their values until the next pulse.

Top module: `bank_conflict_calc`

## Requirements
- R1: A lane's bank is address bits [6:2] and its word identifier is address bits [31:2]. Live lanes that request the same word, whatever their byte offsets and whichever set they come from, count once.
- R2: A lane participates only when its bit in its own set's mask is 1 (bit l of `priMask` for primary lane l; bit s*32+l of `setMask` for lane l of set s).
- R3: Primary lanes participate only when `priShared` is 1.
- R4: The lanes of co-issued set s participate only when `setValid[s]`, `setHasSrc[s]` and `setShared[s]` are all 1.
- R5: `unifiedCycles` is the largest number of distinct words requested in any one bank over the pooled lanes of all participating sets, with no split into sub-groups. It ranges up to 128.
- R6: When no lane participates, `unifiedCycles` is 0 and `unifiedActive` is 0. Otherwise `unifiedActive` is 1 and `unifiedCycles` is at least 1.
- R7: `perSetMaxCycles` is the maximum of `priCycles` (when `priShared` is 1) and `setCycles[s*8 +: 8]` of every set that passes the R4 conditions. It is 0 when none qualifies.
- R8: `outValid` is a one-cycle pulse on the 129th rising edge after the edge that samples `inValid` high.
- R9: An `inValid` strobe, and any change of the data inputs, while a calculation is in progress do not affect its result and start no second one.
- R10: After reset all outputs are 0. Between pulses the outputs hold the last published values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Start strobe; captures all data inputs when the block is idle |
| priAddr | input | 1024 | Primary byte addresses, lane l at bits [l*32 +: 32] |
| priMask | input | 32 | Primary active lanes |
| priShared | input | 1 | Primary access targets shared memory |
| priCycles | input | 8 | Primary's own conflict cycle count |
| setAddr | input | 3072 | Co-issued set addresses, set s lane l at bits [(s*32+l)*32 +: 32] |
| setMask | input | 96 | Co-issued set active lanes, set s lane l at bit s*32+l |
| setValid | input | 3 | Co-issued set holds an operation |
| setHasSrc | input | 3 | Co-issued set has a source instruction |
| setShared | input | 3 | Co-issued set targets shared memory |
| setCycles | input | 24 | Co-issued sets' own cycle counts, set s at [s*8 +: 8] |
| outValid | output | 1 | Result pulse |
| unifiedActive | output | 1 | At least one lane participated |
| unifiedCycles | output | 8 | Pooled bank conflict cycle count |
| perSetMaxCycles | output | 8 | Largest per-set cycle count |

## Verification
The assertions check on every cycle the timing and shape of the result. The pulse lands exactly 129 edges after an accepted strobe and lasts one cycle. The outputs hold between pulses. An inactive result reports zero cycles, and an active result lies between 1 and 128. Whether the count is right can only be shown by the bench's scenarios: deduplication of a word across offsets and sets, masking, the qualification of each set, pooling across sets, and the worst case where all 128 lanes hit one bank. Randomized groups are also compared against a model computed in the bench.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;  // latch the issue group, clear bank counters
    logic step;     // evaluate the slot selected by scanIdx
    logic publish;  // reduce counters and drive the outputs
  } sbcStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SCAN    = 2'd1,
    ST_PUBLISH = 2'd2
  } sbcState_t;

endpackage

// File: rtl/sbc_ctrl.sv
module sbc_ctrl
  import sbc_pkg::*;
#(
  parameter int TOTAL = 128,
  parameter int IDX_W = $clog2(TOTAL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  output sbcStrobes_t      strobes,
  output logic [IDX_W-1:0] scanIdx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);

  sbcState_t stateQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ  <= ST_IDLE;
      scanIdx <= '0;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (inValid) begin
            stateQ  <= ST_SCAN;
            scanIdx <= '0;
          end
        end
        ST_SCAN: begin
          scanIdx <= scanIdx + 1'b1;
          if (scanIdx == LAST_IDX) stateQ <= ST_PUBLISH;
        end
        ST_PUBLISH: stateQ <= ST_IDLE;
        default:    stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.capture = (stateQ == ST_IDLE) && inValid;
    strobes.step    = (stateQ == ST_SCAN);
    strobes.publish = (stateQ == ST_PUBLISH);
  end

endmodule

// File: rtl/sbc_datapath.sv
module sbc_datapath
  import sbc_pkg::*;
#(
  parameter int LANES      = 32,
  parameter int SETS       = 3,
  parameter int BANKS      = 32,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  parameter int CNT_W      = 8,
  parameter int IDX_W      = $clog2(LANES * (SETS + 1))
) (
  input  logic                         clk,
  input  logic                         rst,
  input  sbcStrobes_t                  strobes,
  input  logic [IDX_W-1:0]             scanIdx,
  input  logic [LANES*ADDR_W-1:0]      priAddr,
  input  logic [LANES-1:0]             priMask,
  input  logic                         priShared,
  input  logic [CNT_W-1:0]             priCycles,
  input  logic [SETS*LANES*ADDR_W-1:0] setAddr,
  input  logic [SETS*LANES-1:0]        setMask,
  input  logic [SETS-1:0]              setValid,
  input  logic [SETS-1:0]              setHasSrc,
  input  logic [SETS-1:0]              setShared,
  input  logic [SETS*CNT_W-1:0]        setCycles,
  output logic                         outValid,
  output logic                         unifiedActive,
  output logic [CNT_W-1:0]             unifiedCycles,
  output logic [CNT_W-1:0]             perSetMaxCycles
);

  localparam int TOTAL  = LANES * (SETS + 1);
  localparam int OFF_W  = $clog2(WORD_BYTES);
  localparam int BANK_W = $clog2(BANKS);
  localparam int WORD_W = ADDR_W - OFF_W;

  // Slot view of the incoming group: primary first, then each set
  logic [WORD_W-1:0] wordD [TOTAL];
  logic [TOTAL-1:0]  liveD;
  logic [TOTAL-1:0]  unusedOffBits;

  for (genvar l = 0; l < LANES; l++) begin : gPri
    assign wordD[l]         = priAddr[l*ADDR_W+OFF_W +: WORD_W];
    assign liveD[l]         = priShared & priMask[l];
    assign unusedOffBits[l] = ^priAddr[l*ADDR_W +: OFF_W];
  end

  for (genvar s = 0; s < SETS; s++) begin : gSet
    logic setOn;
    assign setOn = setValid[s] & setHasSrc[s] & setShared[s];
    for (genvar l = 0; l < LANES; l++) begin : gLane
      localparam int SLOT = (s + 1) * LANES + l;
      localparam int SRC  = s * LANES + l;
      assign wordD[SLOT]         = setAddr[SRC*ADDR_W+OFF_W +: WORD_W];
      assign liveD[SLOT]         = setOn & setMask[SRC];
      assign unusedOffBits[SLOT] = ^setAddr[SRC*ADDR_W +: OFF_W];
    end
  end

  // Per-set maximum for comparison
  logic [CNT_W-1:0] perSetD;
  always_comb begin
    perSetD = priShared ? priCycles : '0;
    for (int s = 0; s < SETS; s++) begin
      if (setValid[s] && setHasSrc[s] && setShared[s] &&
          setCycles[s*CNT_W +: CNT_W] > perSetD)
        perSetD = setCycles[s*CNT_W +: CNT_W];
    end
  end

  // Captured group
  logic [WORD_W-1:0] wordQ [TOTAL];
  logic [TOTAL-1:0]  liveQ;
  logic [CNT_W-1:0]  perSetQ;
  logic [CNT_W-1:0]  bankCnt [BANKS];

  always_ff @(posedge clk) begin
    if (strobes.capture) begin
      for (int i = 0; i < TOTAL; i++) wordQ[i] <= wordD[i];
    end
  end

  // Duplicate search: current slot against every earlier live slot
  logic [WORD_W-1:0] curWord;
  logic [BANK_W-1:0] curBank;
  logic              curLive;
  logic [TOTAL-1:0]  hitVec;
  logic              countIt;

  assign curWord = wordQ[scanIdx];
  assign curLive = liveQ[scanIdx];
  assign curBank = curWord[BANK_W-1:0];

  for (genvar j = 0; j < TOTAL; j++) begin : gCmp
    assign hitVec[j] = liveQ[j] && (IDX_W'(j) < scanIdx) && (wordQ[j] == curWord);
  end

  assign countIt = curLive && !(|hitVec);

  always_ff @(posedge clk) begin
    if (rst) begin
      liveQ   <= '0;
      perSetQ <= '0;
      for (int b = 0; b < BANKS; b++) bankCnt[b] <= '0;
    end else if (strobes.capture) begin
      liveQ   <= liveD;
      perSetQ <= perSetD;
      for (int b = 0; b < BANKS; b++) bankCnt[b] <= '0;
    end else if (strobes.step && countIt) begin
      bankCnt[curBank] <= bankCnt[curBank] + 1'b1;
    end
  end

  // Reduction over banks
  logic [CNT_W-1:0] maxCnt;
  always_comb begin
    maxCnt = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (bankCnt[b] > maxCnt) maxCnt = bankCnt[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid        <= 1'b0;
      unifiedActive   <= 1'b0;
      unifiedCycles   <= '0;
      perSetMaxCycles <= '0;
    end else begin
      outValid <= strobes.publish;
      if (strobes.publish) begin
        unifiedActive   <= |liveQ;
        unifiedCycles   <= maxCnt;
        perSetMaxCycles <= perSetQ;
      end
    end
  end

endmodule

// File: rtl/bank_conflict_calc.sv
module bank_conflict_calc
  import sbc_pkg::*;
#(
  parameter int LANES      = 32,
  parameter int SETS       = 3,
  parameter int BANKS      = 32,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  parameter int CNT_W      = $clog2(LANES * (SETS + 1) + 1)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         inValid,
  input  logic [LANES*ADDR_W-1:0]      priAddr,
  input  logic [LANES-1:0]             priMask,
  input  logic                         priShared,
  input  logic [CNT_W-1:0]             priCycles,
  input  logic [SETS*LANES*ADDR_W-1:0] setAddr,
  input  logic [SETS*LANES-1:0]        setMask,
  input  logic [SETS-1:0]              setValid,
  input  logic [SETS-1:0]              setHasSrc,
  input  logic [SETS-1:0]              setShared,
  input  logic [SETS*CNT_W-1:0]        setCycles,
  output logic                         outValid,
  output logic                         unifiedActive,
  output logic [CNT_W-1:0]             unifiedCycles,
  output logic [CNT_W-1:0]             perSetMaxCycles
);

  localparam int TOTAL = LANES * (SETS + 1);
  localparam int IDX_W = $clog2(TOTAL);

  sbcStrobes_t      strobes;
  logic [IDX_W-1:0] scanIdx;

  sbc_ctrl #(
    .TOTAL(TOTAL),
    .IDX_W(IDX_W)
  ) uCtrl (
    .clk    (clk),
    .rst    (rst),
    .inValid(inValid),
    .strobes(strobes),
    .scanIdx(scanIdx)
  );

  sbc_datapath #(
    .LANES     (LANES),
    .SETS      (SETS),
    .BANKS     (BANKS),
    .ADDR_W    (ADDR_W),
    .WORD_BYTES(WORD_BYTES),
    .CNT_W     (CNT_W),
    .IDX_W     (IDX_W)
  ) uDp (
    .clk            (clk),
    .rst            (rst),
    .strobes        (strobes),
    .scanIdx        (scanIdx),
    .priAddr        (priAddr),
    .priMask        (priMask),
    .priShared      (priShared),
    .priCycles      (priCycles),
    .setAddr        (setAddr),
    .setMask        (setMask),
    .setValid       (setValid),
    .setHasSrc      (setHasSrc),
    .setShared      (setShared),
    .setCycles      (setCycles),
    .outValid       (outValid),
    .unifiedActive  (unifiedActive),
    .unifiedCycles  (unifiedCycles),
    .perSetMaxCycles(perSetMaxCycles)
  );

endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
  parameter int TOTAL = 128,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             outValid,
  input logic             unifiedActive,
  input logic [CNT_W-1:0] unifiedCycles,
  input logic [CNT_W-1:0] perSetMaxCycles
);

  localparam logic [15:0] LAT = 16'(TOTAL + 1);

  // Independent tracking of when a result is due
  logic        busy;
  logic [15:0] waitCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      waitCnt <= '0;
    end else if (inValid && (!busy || outValid)) begin
      busy    <= 1'b1;
      waitCnt <= '0;
    end else if (busy && outValid) begin
      busy <= 1'b0;
    end else if (busy) begin
      waitCnt <= waitCnt + 1'b1;
    end
  end

  // R8
  latency_early_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (busy && waitCnt == LAT));

  // R8
  latency_late_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && waitCnt == LAT) |-> outValid);

  // R8
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);

  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !unifiedActive) |-> (unifiedCycles == '0));

  // R5
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && unifiedActive) |-> (unifiedCycles != '0 && unifiedCycles <= CNT_W'(TOTAL)));

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> ($stable(unifiedCycles) && $stable(unifiedActive) && $stable(perSetMaxCycles)));

endmodule

bind bank_conflict_calc sbc_checker #(
  .TOTAL(LANES * (SETS + 1)),
  .CNT_W(CNT_W)
) uChk (
  .clk            (clk),
  .rst            (rst),
  .inValid        (inValid),
  .outValid       (outValid),
  .unifiedActive  (unifiedActive),
  .unifiedCycles  (unifiedCycles),
  .perSetMaxCycles(perSetMaxCycles)
);

// File: tb/sim_bank_conflict_calc.sv
module sim_bank_conflict_calc;

  localparam int LANES = 32;
  localparam int SETS  = 3;
  localparam int CNT_W = 8;
  localparam int LAT   = 129;

  logic                     clk = 1'b0;
  logic                     rst = 1'b1;
  logic                     inValid = 1'b0;
  logic [LANES*32-1:0]      priAddr = '0;
  logic [LANES-1:0]         priMask = '0;
  logic                     priShared = 1'b0;
  logic [CNT_W-1:0]         priCycles = '0;
  logic [SETS*LANES*32-1:0] setAddr = '0;
  logic [SETS*LANES-1:0]    setMask = '0;
  logic [SETS-1:0]          setValid = '0;
  logic [SETS-1:0]          setHasSrc = '0;
  logic [SETS-1:0]          setShared = '0;
  logic [SETS*CNT_W-1:0]    setCycles = '0;
  logic                     outValid;
  logic                     unifiedActive;
  logic [CNT_W-1:0]         unifiedCycles;
  logic [CNT_W-1:0]         perSetMaxCycles;

  always #4 clk = ~clk;  // 125 MHz

  bank_conflict_calc u0 (
    .clk(clk), .rst(rst), .inValid(inValid),
    .priAddr(priAddr), .priMask(priMask), .priShared(priShared), .priCycles(priCycles),
    .setAddr(setAddr), .setMask(setMask), .setValid(setValid), .setHasSrc(setHasSrc),
    .setShared(setShared), .setCycles(setCycles),
    .outValid(outValid), .unifiedActive(unifiedActive),
    .unifiedCycles(unifiedCycles), .perSetMaxCycles(perSetMaxCycles)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clearAll();
    priAddr = '0; priMask = '0; priShared = 1'b0; priCycles = '0;
    setAddr = '0; setMask = '0; setValid = '0; setHasSrc = '0;
    setShared = '0; setCycles = '0;
  endtask

  function automatic void putP(int l, logic [31:0] a);
    priAddr[l*32 +: 32] = a;
  endfunction

  function automatic void putS(int s, int l, logic [31:0] a);
    setAddr[(s*LANES+l)*32 +: 32] = a;
  endfunction

  function automatic void enableSet(int s, int cyc);
    setValid[s] = 1'b1; setHasSrc[s] = 1'b1; setShared[s] = 1'b1;
    setMask[s*LANES +: LANES] = '1;
    setCycles[s*CNT_W +: CNT_W] = CNT_W'(cyc);
  endfunction

  int gotU, gotA, gotP;

  // Strobe, wait for the pulse, check latency, capture the outputs
  task automatic runGroup();
    int edges;
    @(negedge clk); inValid = 1'b1;
    @(negedge clk); inValid = 1'b0;
    edges = 1;
    while (!outValid && edges < 400) begin
      @(negedge clk); edges++;
    end
    chk("R8 latency", edges - 1, LAT);
    gotU = int'(unifiedCycles);
    gotA = int'(unifiedActive);
    gotP = int'(perSetMaxCycles);
    @(negedge clk);
    chk("R8 single pulse", int'(outValid), 0);
  endtask

  // Model of the requirements for randomized groups
  task automatic model(output int eU, output int eA, output int eP);
    logic [29:0] w [128];
    bit          lv [128];
    int          cnt [32];
    bit          on;
    for (int l = 0; l < LANES; l++) begin
      w[l]  = priAddr[l*32+2 +: 30];
      lv[l] = priShared && priMask[l];
    end
    for (int s = 0; s < SETS; s++) begin
      on = setValid[s] && setHasSrc[s] && setShared[s];
      for (int l = 0; l < LANES; l++) begin
        w[(s+1)*LANES+l]  = setAddr[(s*LANES+l)*32+2 +: 30];
        lv[(s+1)*LANES+l] = on && setMask[s*LANES+l];
      end
    end
    for (int b = 0; b < 32; b++) cnt[b] = 0;
    eA = 0;
    for (int i = 0; i < 128; i++) begin
      if (lv[i]) begin
        bit dup = 0;
        eA = 1;
        for (int j = 0; j < i; j++) if (lv[j] && w[j] == w[i]) dup = 1;
        if (!dup) cnt[w[i][4:0]]++;
      end
    end
    eU = 0;
    for (int b = 0; b < 32; b++) if (cnt[b] > eU) eU = cnt[b];
    eP = priShared ? int'(priCycles) : 0;
    for (int s = 0; s < SETS; s++)
      if (setValid[s] && setHasSrc[s] && setShared[s] &&
          int'(setCycles[s*CNT_W +: CNT_W]) > eP)
        eP = int'(setCycles[s*CNT_W +: CNT_W]);
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int eU, eA, eP, seen;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 reset outValid", int'(outValid), 0);
    chk("R10 reset unified", int'(unifiedCycles), 0);
    chk("R10 reset active", int'(unifiedActive), 0);
    chk("R10 reset perSet", int'(perSetMaxCycles), 0);

    // R1 broadcast, varying byte offsets inside one word
    clearAll(); priShared = 1; priMask = '1; priCycles = 8'd31;
    for (int l = 0; l < LANES; l++) putP(l, 32'h0000_0100 + 32'(l % 4));
    runGroup();
    chk("R1 broadcast", gotU, 1);
    chk("R6 active", gotA, 1);
    chk("R7 primary only", gotP, 31);

    // R1 stride 4: one word per bank
    clearAll(); priShared = 1; priMask = '1;
    for (int l = 0; l < LANES; l++) putP(l, 32'(4 * l));
    runGroup();
    chk("R1 stride4", gotU, 1);

    // R5 stride 128: all in bank 0, distinct words
    clearAll(); priShared = 1; priMask = '1;
    for (int l = 0; l < LANES; l++) putP(l, 32'(128 * l));
    runGroup();
    chk("R5 stride128", gotU, 32);

    // R5 pooling: two conflict-free sets collide per bank
    clearAll(); priShared = 1; priMask = '1; priCycles = 1;
    for (int l = 0; l < LANES; l++) begin
      putP(l, 32'(4 * l)); putS(0, l, 32'h1000 + 32'(4 * l));
    end
    enableSet(0, 1);
    runGroup();
    chk("R5 pooled", gotU, 2);
    chk("R7 pooled perSet", gotP, 1);

    // R5 worst case: all 128 lanes distinct words in one bank
    clearAll(); priShared = 1; priMask = '1;
    for (int s = 0; s < SETS; s++) enableSet(s, 0);
    for (int l = 0; l < LANES; l++) begin
      putP(l, 32'(128 * l));
      for (int s = 0; s < SETS; s++) putS(s, l, 32'(128 * ((s + 1) * 32 + l)));
    end
    runGroup();
    chk("R5 full", gotU, 128);

    // R1 duplicates across sets count once
    clearAll(); priShared = 1; priMask = 32'h0000_FFFF;
    for (int l = 0; l < LANES; l++) begin
      putP(l, 32'(128 * l)); putS(0, l, 32'(128 * l) + 32'd2);
    end
    enableSet(0, 0); setMask[15:0] = '1; setMask[31:16] = '0;
    runGroup();
    chk("R1 cross-set dedup", gotU, 16);

    // R2 masking
    clearAll(); priShared = 1; priMask = 32'h8000_00FF;
    for (int l = 0; l < LANES; l++) putP(l, 32'(128 * l));
    runGroup();
    chk("R2 mask", gotU, 9);

    // R3 primary not shared
    clearAll(); priShared = 0; priMask = '1; priCycles = 50;
    for (int l = 0; l < LANES; l++) begin
      putP(l, 32'(128 * l)); putS(0, l, 32'(128 * l) + 32'h2000);
    end
    enableSet(0, 7); setMask[31:10] = '0;
    runGroup();
    chk("R3 unified", gotU, 10);
    chk("R3 perSet", gotP, 7);

    // R4 each disqualifying flag
    clearAll(); priShared = 1; priMask = '1; priCycles = 3;
    for (int l = 0; l < LANES; l++) begin
      putP(l, 32'(4 * l));
      for (int s = 0; s < SETS; s++) putS(s, l, 32'(128 * l) + 32'h4000);
    end
    for (int s = 0; s < SETS; s++) enableSet(s, 99);
    setValid[0] = 0; setHasSrc[1] = 0; setShared[2] = 0;
    runGroup();
    chk("R4 unified", gotU, 1);
    chk("R4 perSet", gotP, 3);

    // R6 nothing participates
    clearAll(); priMask = '1; enableSet(1, 9); setShared[1] = 0;
    runGroup();
    chk("R6 none unified", gotU, 0);
    chk("R6 none active", gotA, 0);
    chk("R7 none perSet", gotP, 0);

    // R6 shared primary with empty mask
    clearAll(); priShared = 1; priCycles = 5;
    runGroup();
    chk("R6 empty mask active", gotA, 0);
    chk("R6 empty mask unified", gotU, 0);
    chk("R7 empty mask perSet", gotP, 5);

    // R7 maximum over sets
    clearAll(); priShared = 1; priCycles = 6;
    enableSet(0, 4); enableSet(1, 9); enableSet(2, 2);
    runGroup();
    chk("R7 max", gotP, 9);

    // R9 strobe and data change during a calculation
    clearAll(); priShared = 1; priMask = '1;
    for (int l = 0; l < LANES; l++) putP(l, 32'(128 * l));
    @(negedge clk); inValid = 1'b1;
    @(negedge clk); inValid = 1'b0;
    repeat (20) @(negedge clk);
    for (int l = 0; l < LANES; l++) putP(l, 32'h100);
    inValid = 1'b1;
    @(negedge clk); inValid = 1'b0;
    seen = 0;
    while (!outValid && seen < 400) begin @(negedge clk); seen++; end
    chk("R9 first result kept", int'(unifiedCycles), 32);
    seen = 0;
    repeat (LAT + 5) begin @(negedge clk); if (outValid) seen++; end
    chk("R9 no second result", seen, 0);

    // R10 hold with changing inputs and no strobe
    for (int l = 0; l < LANES; l++) putP(l, 32'(4 * l));
    priCycles = 77;
    repeat (10) @(negedge clk);
    chk("R10 hold unified", int'(unifiedCycles), 32);
    chk("R10 hold perSet", int'(perSetMaxCycles), 0);

    // R5/R1/R2/R4/R7 randomized groups against the model
    for (int it = 0; it < 40; it++) begin
      logic [31:0] amask;
      amask = (it % 3 == 0) ? 32'h0000_007F : ((it % 3 == 1) ? 32'h0000_0FFF : 32'h0003_FFFF);
      clearAll();
      priShared = 1'($urandom);
      priMask   = $urandom | $urandom;
      priCycles = 8'($urandom);
      setValid  = 3'($urandom | $urandom);
      setHasSrc = 3'($urandom | $urandom);
      setShared = 3'($urandom | $urandom);
      setCycles = 24'($urandom);
      for (int s = 0; s < SETS; s++) setMask[s*LANES +: LANES] = $urandom | $urandom;
      for (int l = 0; l < LANES; l++) begin
        putP(l, $urandom & amask);
        for (int s = 0; s < SETS; s++) putS(s, l, $urandom & amask);
      end
      model(eU, eA, eP);
      runGroup();
      chk("R5 random unified", gotU, eU);
      chk("R6 random active", gotA, eA);
      chk("R7 random perSet", gotP, eP);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule